// File: doc/BRIEF.md
# Terminal Sync Timing and Frame-Counted Alarm Generator

This block derives the horizontal and vertical sync pulses of a character terminal from one free-running clock. The clock rate is a parameter. At elaboration the block turns it, together with the line rate and the two pulse widths, into the terminal values of a line counter and a frame counter. A single input chooses a 50 Hz or 60 Hz frame rate to match the mains supply. The nominal line rate is 15.720 kHz, so a frame holds 314 lines at 50 Hz and 262 lines at 60 Hz.

The block also drives an audio alarm line. A request on `beep_req` arms one alarm. The alarm begins at the next frame start and lasts a fixed number of whole frames. With the default of 15 frames, the alarm lasts 300 ms at 50 Hz and 250 ms at 60 Hz. Both values fall inside the window required for each mains rate. Software or a neighbouring block drives the request. The level on `audio` gates an external tone source.

Top module: `sync_beep_gen`

## Requirements
- R1: While `rst_n` is low, `hsync`, `vsync` and `audio` are all 0.
- R2: A line lasts H = floor(CLK_HZ / LINE_HZ) clocks. `hsync` is 1 for the first HS clocks of every line, where HS = round(CLK_HZ × HSYNC_NS / 1e9).
- R3: A frame holds floor(LINE_HZ / 60) lines when `mains_50hz` = 0 and floor(LINE_HZ / 50) lines when `mains_50hz` = 1. With the default line rate these are 262 and 314 lines.
- R4: `vsync` is 1 for the first VS lines of every frame, where VS = round(LINE_HZ × VSYNC_NS / 1e9), which is 3 by default. `vsync` rises in the same cycle as an `hsync` rising edge.
- R5: `mains_50hz` is sampled only at the clock edge that starts a new frame. A change in the middle of a frame leaves the current frame's length unchanged.
- R6: When no alarm is pending or sounding, a cycle with `beep_req` = 1 arms an alarm, and `audio` rises in the same cycle as the next `vsync` rising edge.
- R7: Once risen, `audio` stays 1 for exactly BEEP_FRAMES frames (15 by default) and falls in the same cycle as the `vsync` rising edge that starts the following frame.
- R8: A `beep_req` while an alarm is pending or sounding is ignored. It neither extends the alarm nor queues another one.
- R9: The first line and the first frame start at the first clock edge after `rst_n` rises. The first frame uses the rate on `mains_50hz` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, rate given by parameter CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| mains_50hz | input | 1 | Frame-rate select: 1 = 50 Hz, 0 = 60 Hz |
| beep_req | input | 1 | Alarm request, sampled every clock |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| audio | output | 1 | Alarm enable level, active high |

## Verification
The bench uses a reduced clock of ten clocks per line. It walks through many consecutive frames and predicts every cycle of `hsync`, `vsync` and `audio` from the frame's start cycle. The frame rate changes in an irregular pattern, and each change is applied in the middle of the previous frame. A wrong frame length therefore shows up in the next frame's alignment, and a rate sampled too early shows up in the current frame.

Alarm requests are placed at several points:
- an ordinary mid-frame request;
- a request repeated while the alarm is still pending;
- a request during the sounding alarm;
- a request in the last cycle of the alarm's last frame;
- a request in the final cycle before a frame wrap.

These placements separate a correct single alarm from one that retriggers, one that is extended, and one that starts a frame late.

// File: rtl/sync_beep_pkg.sv
package sync_beep_pkg;

    typedef enum logic {
        RATE_60 = 1'b0,
        RATE_50 = 1'b1
    } rate_e;

    typedef enum logic [1:0] {
        BP_IDLE = 2'd0,
        BP_PEND = 2'd1,
        BP_ON   = 2'd2
    } beep_state_e;

    function automatic int unsigned div_round(input longint unsigned num,
                                              input longint unsigned den);
        return int'((num + den / 2) / den);
    endfunction

    function automatic int unsigned clks_per_line(input longint unsigned clk_hz,
                                                  input longint unsigned line_hz);
        return int'(clk_hz / line_hz);
    endfunction

    function automatic int unsigned width_in_clks(input longint unsigned clk_hz,
                                                  input longint unsigned ns);
        return div_round(clk_hz * ns, 64'd1_000_000_000);
    endfunction

    function automatic int unsigned lines_per_frame(input longint unsigned line_hz,
                                                    input longint unsigned frame_hz);
        return int'(line_hz / frame_hz);
    endfunction

    function automatic int unsigned width_in_lines(input longint unsigned line_hz,
                                                   input longint unsigned ns);
        return div_round(line_hz * ns, 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/sbg_line_timer.sv
module sbg_line_timer #(
    parameter int unsigned H_TOTAL = 1603,
    parameter int unsigned H_SYNC  = 302
) (
    input  logic clk,
    input  logic rst_n,
    output logic hsync,
    output logic line_last
);
    localparam int unsigned HW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1;

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          hs;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        line_last = (st_q.cnt == HW'(H_TOTAL - 1));
        if (line_last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + HW'(1);
        end
        st_d.hs = (st_d.cnt < HW'(H_SYNC));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= HW'(H_TOTAL - 1);
            st_q.hs  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync = st_q.hs;

endmodule

// File: rtl/sbg_frame_timer.sv
module sbg_frame_timer
    import sync_beep_pkg::*;
#(
    parameter int unsigned V_50   = 314,
    parameter int unsigned V_60   = 262,
    parameter int unsigned V_SYNC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_last,
    input  logic mains_50hz,
    output logic vsync,
    output logic frame_wrap
);
    localparam int unsigned V_MAX = (V_50 > V_60) ? V_50 : V_60;
    localparam int unsigned VW    = (V_MAX > 1) ? $clog2(V_MAX) : 1;

    typedef struct packed {
        logic [VW-1:0] cnt;
        rate_e         rate;
        logic          vs;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic      last_line;

    always_comb begin
        st_d      = st_q;
        last_line = (st_q.rate == RATE_50) ? (st_q.cnt == VW'(V_50 - 1))
                                           : (st_q.cnt == VW'(V_60 - 1));
        frame_wrap = line_last && last_line;
        if (line_last) begin
            if (last_line) begin
                st_d.cnt  = '0;
                st_d.rate = rate_e'(mains_50hz);
            end else begin
                st_d.cnt = st_q.cnt + VW'(1);
            end
        end
        st_d.vs = (st_d.cnt < VW'(V_SYNC));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= VW'(V_60 - 1);
            st_q.rate <= RATE_60;
            st_q.vs   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vsync = st_q.vs;

endmodule

// File: rtl/sbg_beep_ctrl.sv
module sbg_beep_ctrl
    import sync_beep_pkg::*;
#(
    parameter int unsigned BEEP_FRAMES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beep_req,
    input  logic frame_wrap,
    output logic audio
);
    localparam int unsigned FW = (BEEP_FRAMES > 1) ? $clog2(BEEP_FRAMES) : 1;

    typedef struct packed {
        beep_state_e   st;
        logic [FW-1:0] fcnt;
        logic          aud;
    } beep_st_t;

    beep_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            BP_IDLE: begin
                if (beep_req && frame_wrap) begin
                    st_d.st   = BP_ON;
                    st_d.fcnt = '0;
                end else if (beep_req) begin
                    st_d.st = BP_PEND;
                end
            end
            BP_PEND: begin
                if (frame_wrap) begin
                    st_d.st   = BP_ON;
                    st_d.fcnt = '0;
                end
            end
            BP_ON: begin
                if (frame_wrap) begin
                    if (st_q.fcnt == FW'(BEEP_FRAMES - 1)) begin
                        st_d.st   = BP_IDLE;
                        st_d.fcnt = '0;
                    end else begin
                        st_d.fcnt = st_q.fcnt + FW'(1);
                    end
                end
            end
            default: begin
                st_d.st   = BP_IDLE;
                st_d.fcnt = '0;
            end
        endcase
        st_d.aud = (st_d.st == BP_ON);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.st   <= BP_IDLE;
            st_q.fcnt <= '0;
            st_q.aud  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign audio = st_q.aud;

endmodule

// File: rtl/sync_beep_gen.sv
module sync_beep_gen
    import sync_beep_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 25_200_000,
    parameter int unsigned LINE_HZ     = 15_720,
    parameter int unsigned HSYNC_NS    = 12_000,
    parameter int unsigned VSYNC_NS    = 192_000,
    parameter int unsigned BEEP_FRAMES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mains_50hz,
    input  logic beep_req,
    output logic hsync,
    output logic vsync,
    output logic audio
);
    localparam int unsigned H_TOTAL = clks_per_line(CLK_HZ, LINE_HZ);
    localparam int unsigned H_SYNC  = width_in_clks(CLK_HZ, HSYNC_NS);
    localparam int unsigned V_50    = lines_per_frame(LINE_HZ, 50);
    localparam int unsigned V_60    = lines_per_frame(LINE_HZ, 60);
    localparam int unsigned V_SYNC  = width_in_lines(LINE_HZ, VSYNC_NS);

    logic line_last;
    logic frame_wrap;

    sbg_line_timer #(
        .H_TOTAL (H_TOTAL),
        .H_SYNC  (H_SYNC)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .line_last (line_last)
    );

    sbg_frame_timer #(
        .V_50   (V_50),
        .V_60   (V_60),
        .V_SYNC (V_SYNC)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_last  (line_last),
        .mains_50hz (mains_50hz),
        .vsync      (vsync),
        .frame_wrap (frame_wrap)
    );

    sbg_beep_ctrl #(
        .BEEP_FRAMES (BEEP_FRAMES)
    ) u_beep (
        .clk        (clk),
        .rst_n      (rst_n),
        .beep_req   (beep_req),
        .frame_wrap (frame_wrap),
        .audio      (audio)
    );

endmodule

// File: rtl/sync_beep_chk.sv
module sync_beep_chk
    import sync_beep_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 25_200_000,
    parameter int unsigned LINE_HZ     = 15_720,
    parameter int unsigned HSYNC_NS    = 12_000,
    parameter int unsigned BEEP_FRAMES = 15
) (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic vsync,
    input logic audio
);
    localparam int unsigned H_TOTAL = clks_per_line(CLK_HZ, LINE_HZ);
    localparam int unsigned H_SYNC  = width_in_clks(CLK_HZ, HSYNC_NS);

    int unsigned hs_high_q;
    int unsigned hs_per_q;
    logic        hs_seen_q;
    int unsigned aud_frames_q;
    logic        vs_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_high_q    <= 0;
            hs_per_q     <= 0;
            hs_seen_q    <= 1'b0;
            aud_frames_q <= 0;
            vs_prev_q    <= 1'b0;
        end else begin
            vs_prev_q <= vsync;
            hs_high_q <= hsync ? hs_high_q + 1 : 0;
            if (hsync && !hs_high_q[0] && hs_high_q == 0) begin
                hs_per_q  <= 1;
                hs_seen_q <= 1'b1;
            end else begin
                hs_per_q <= hs_per_q + 1;
            end
            if (!audio) begin
                aud_frames_q <= 0;
            end else if (vsync && !vs_prev_q) begin
                aud_frames_q <= aud_frames_q + 1;
            end
        end
    end

    AST_OUTPUTS_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> (!hsync && !vsync && !audio));                     // R1

    AST_HS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync) |-> (hs_high_q == H_SYNC));                       // R2

    AST_HS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hsync) && hs_seen_q) |-> (hs_per_q == H_TOTAL));       // R2

    AST_VS_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> $rose(hsync));                                // R4

    AST_AUDIO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(audio) |-> $rose(vsync));                                // R6

    AST_AUDIO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(vsync) |-> $stable(audio));                             // R8

    AST_AUDIO_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(audio) |-> ($rose(vsync) && aud_frames_q == BEEP_FRAMES)); // R7

endmodule

bind sync_beep_gen sync_beep_chk #(
    .CLK_HZ      (CLK_HZ),
    .LINE_HZ     (LINE_HZ),
    .HSYNC_NS    (HSYNC_NS),
    .BEEP_FRAMES (BEEP_FRAMES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .hsync (hsync),
    .vsync (vsync),
    .audio (audio)
);

// File: tb/sim_sync_beep_gen.sv
module sim_sync_beep_gen;
    localparam int CLK_PERIOD  = 10;
    localparam int CLK_HZ      = 157_200;
    localparam int LINE_HZ     = 15_720;
    localparam int BEEP_FRAMES = 15;
    localparam int H           = 10;   // 157200 / 15720
    localparam int HS          = 2;    // round(12 us * 157.2 kHz)
    localparam int VS          = 3;    // round(192 us * 15.72 kHz)
    localparam int V50         = 314;
    localparam int V60         = 262;
    localparam int NF          = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mains_50hz = 1'b0;
    logic beep_req = 1'b0;
    logic hsync, vsync, audio;

    int checks = 0;
    int errors = 0;
    int cur_f = 0;
    int cur_o = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_beep_gen #(
        .CLK_HZ      (CLK_HZ),
        .LINE_HZ     (LINE_HZ),
        .HSYNC_NS    (12_000),
        .VSYNC_NS    (192_000),
        .BEEP_FRAMES (BEEP_FRAMES)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mains_50hz (mains_50hz),
        .beep_req   (beep_req),
        .hsync      (hsync),
        .vsync      (vsync),
        .audio      (audio)
    );

    function automatic bit rate50(input int f);
        return ((f % 3) == 1) || ((f % 5) == 0);
    endfunction

    function automatic bit aud_exp(input int f);
        return (f >= 2 && f <= 1 + BEEP_FRAMES) || (f >= 19 && f <= 18 + BEEP_FRAMES);
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (frame %0d offset %0d)",
                     tag, what, act, exp, cur_f, cur_o);
        end
    endtask

    initial begin
        mains_50hz = rate50(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "hsync in reset", hsync, 1'b0);
        chk("R1", "vsync in reset", vsync, 1'b0);
        chk("R1", "audio in reset", audio, 1'b0);
        rst_n = 1'b1;
        for (int f = 0; f < NF; f++) begin
            int len;
            len = H * (rate50(f) ? V50 : V60);
            for (int o = 0; o < len; o++) begin
                string htag;
                string vtag;
                string atag;
                @(posedge clk);
                @(negedge clk);
                cur_f = f;
                cur_o = o;
                htag = (f == 0) ? "R9" : "R2";
                vtag = (f == 0) ? "R9" : (rate50(f) != rate50(f - 1)) ? "R5" : "R3";
                if (f == 2 || f == 19)       atag = "R6";
                else if (f == 17 || f == 7)  atag = "R8";
                else                         atag = "R7";
                chk(htag, "hsync", hsync, ((o % H) < HS));
                chk(vtag, "vsync R4", vsync, ((o / H) < VS));
                chk(atag, "audio", audio, aud_exp(f));
                // rate for the next frame changes mid-frame (R5)
                if (o == len / 2) mains_50hz = rate50(f + 1);
                // alarm requests, each high for one sampling edge
                beep_req = (f == 1 && o == 100)      // arms alarm: R6
                        || (f == 1 && o == 200)      // while pending: R8
                        || (f == 6 && o == 50)       // while sounding: R8
                        || (f == 16 && o == len - 1) // last alarm frame: R8
                        || (f == 18 && o == len - 1);// at frame wrap: R6
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200_000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule